// File: doc/BRIEF.md
# UART Register Front End

This block is the processor-facing side of a serial port. A single data address carries traffic both ways. A bus write to it places a byte in a transmit holding buffer. A bus read from it returns the oldest byte of a two-entry receive queue and removes that byte. A second address presents the status flags: receive-complete, transmit-complete, data-register-empty and a sticky overrun bit. The three completion flags also leave the block as interrupt request lines.

Timing and bit-level shifting are handled by neighbouring logic, which the block sees through a minimal handshake. On the transmit side, the block pulses a load strobe together with the character, and the shifter later pulses a frame-done strobe. On the receive side, the shifter presents a character with a one-cycle valid strobe.

A character-size selector sets the frame to 5, 6, 7 or 8 data bits. Bits above that width are dropped on the way out and forced to zero on the way in.

Top module: `uart_regs`

## Requirements
- R1: After a synchronous reset, `irq_dre` is 1, `irq_txc` and `irq_rxc` are 0, `ser_load` is 0 and `bus_rdata` is 0.
- R2: A write to address 0 while `irq_dre` is 1 stores the byte in the holding buffer. `irq_dre` reads 0 from the next cycle.
- R3: A write to address 0 while `irq_dre` is 0 is ignored. The byte already held is the one later handed to the shifter.
- R4: When `tx_enable` is 1, the holding buffer is full and the shifter is idle, `ser_load` pulses for exactly one cycle and `irq_dre` returns to 1 in that same cycle. The shifter is idle when no load has been issued since the last `ser_done`. No load is issued in the cycle after a cycle with `tx_enable` at 0.
- R5: A `ser_done` pulse while the shifter is busy ends the frame. If the holding buffer was empty in that cycle, `irq_txc` is 1 from the next cycle. If the buffer was full, `irq_txc` is not set.
- R6: `irq_txc` is cleared by a write to address 1 with bit 6 set, or by `txc_ack`. A write to address 1 with bit 6 at 0 leaves it unchanged. When a frame end and a clear fall in the same cycle, the flag ends up set.
- R7: A read of address 0 puts the oldest queued byte on `bus_rdata` in the next cycle and removes it from the queue. A read of an empty queue returns 0. Reads of addresses 2 and 3 return 0.
- R8: `irq_rxc` is 1 exactly when the receive queue holds at least one byte. The queue holds up to two bytes.
- R9: A character arriving while the queue holds two bytes is discarded, and status bit 3 (overrun) becomes 1. A read that removes a byte clears the overrun bit. If a removing read and an arrival fall in the same cycle on a full queue, the arrival is kept.
- R10: While `rx_enable` is 0, the queue and the overrun bit are cleared and arriving characters are discarded.
- R11: `char_size` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. `ser_data` carries the held byte masked to that width at the time of the load. Received bytes are masked at the time they arrive.
- R12: A read of address 1 returns the status byte: bit 7 receive-complete, bit 6 transmit-complete, bit 5 data-register-empty, bit 3 overrun, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| txc_ack | input | 1 | Transmit-complete interrupt acknowledge |
| tx_enable | input | 1 | Allows handing bytes to the shifter |
| rx_enable | input | 1 | Receiver enable; 0 flushes the queue |
| char_size | input | 2 | Character width select (5 to 8 bits) |
| ser_load | output | 1 | One-cycle load strobe to the transmit shifter |
| ser_data | output | 8 | Character for the transmit shifter |
| ser_done | input | 1 | Frame-done pulse from the transmit shifter |
| rx_valid | input | 1 | Received-character strobe |
| rx_char | input | 8 | Received character |
| irq_rxc | output | 1 | Receive-complete request |
| irq_txc | output | 1 | Transmit-complete request |
| irq_dre | output | 1 | Data-register-empty request |

## Verification
The two functions most likely to collide are a removing read of the data address and a character arriving from the shifter when the queue is already full. The overrun rule has to judge that case by the occupancy left after the read, not the occupancy before it. This collision is driven once on purpose: the queue is filled with two bytes, and then the read and the arrival are issued in the same cycle. It also arises often in a long random run. The bench checks it against a queue model that applies the pop before the push. It requires all three bytes to come back in order with no overrun flagged. A second overlap, a frame end in the same cycle as a transmit-complete clear, is forced directly and must leave the flag set.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int AD_DATA  = 0;
  localparam int AD_STAT  = 1;
  localparam int SB_RXC   = 7;
  localparam int SB_TXC   = 6;
  localparam int SB_DRE   = 5;
  localparam int SB_OVR   = 3;
  localparam int CSEL_W   = 2;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_enable,
  input  logic [CSEL_W-1:0] char_sel,
  input  logic              ser_done,
  input  logic              txc_clr,
  output logic              ser_load,
  output logic [DATA_W-1:0] ser_data,
  output logic              dre,
  output logic              txc
);
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [CSEL_W-1:0] CSEL_MAX = '1;

  logic [DATA_W-1:0] hold_q, sdata_q, width_mask;
  logic              full_q, busy_q, load_q, txc_q;
  logic              load_go, frame_end;

  assign width_mask = ONES >> (CSEL_MAX - char_sel);
  assign load_go    = tx_enable && full_q && !busy_q;
  assign frame_end  = ser_done && busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      sdata_q <= '0;
      full_q  <= 1'b0;
      busy_q  <= 1'b0;
      load_q  <= 1'b0;
      txc_q   <= 1'b0;
    end else begin
      load_q <= load_go;
      if (load_go) sdata_q <= hold_q & width_mask;
      if (wr_stb && !full_q) begin
        hold_q <= wdata;
        full_q <= 1'b1;
      end else if (load_go) begin
        full_q <= 1'b0;
      end
      if (load_go) busy_q <= 1'b1;
      else if (frame_end) busy_q <= 1'b0;
      if (frame_end && !full_q) txc_q <= 1'b1;
      else if (txc_clr) txc_q <= 1'b0;
    end
  end

  assign ser_load = load_q;
  assign ser_data = sdata_q;
  assign dre      = !full_q;
  assign txc      = txc_q;

  a_r3_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && full_q) |=> (hold_q == $past(hold_q)));
  a_r2_dre_drops: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && dre) |=> !dre);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ser_load |=> !ser_load);
  a_r4_gated: assert property (@(posedge clk) disable iff (rst)
    !tx_enable |=> !ser_load);
  a_r5_txc_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(txc) |-> $past(ser_done));
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (txc_clr && !ser_done) |=> !txc);
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_regs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_enable,
  input  logic              push_stb,
  input  logic [DATA_W-1:0] push_data,
  input  logic [CSEL_W-1:0] char_sel,
  input  logic              pop_stb,
  output logic [DATA_W-1:0] head_data,
  output logic              not_empty,
  output logic              overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [CSEL_W-1:0] CSEL_MAX = '1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              ovr_q, is_full, is_empty, pop_go, push_ok, drop;
  logic [DATA_W-1:0] width_mask;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign width_mask = ONES >> (CSEL_MAX - char_sel);
  assign is_full    = (count == CNT_W'(DEPTH));
  assign is_empty   = (count == '0);
  assign pop_go     = pop_stb && !is_empty;
  assign push_ok    = push_stb && (!is_full || pop_go);
  assign drop       = push_stb && is_full && !pop_go;

  always_ff @(posedge clk) begin
    if (rx_enable && push_ok) mem[wr_ptr] <= push_data & width_mask;
  end

  always_ff @(posedge clk) begin
    if (rst || !rx_enable) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_go)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_go})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (drop) ovr_q <= 1'b1;
      else if (pop_go) ovr_q <= 1'b0;
    end
  end

  assign head_data = is_empty ? '0 : mem[rd_ptr];
  assign not_empty = !is_empty;
  assign overrun   = ovr_q;

  a_r8_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  a_r10_flush: assert property (@(posedge clk) disable iff (rst)
    !rx_enable |=> !not_empty && !overrun);
  a_r9_ovr_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(push_stb && is_full));
endmodule

// File: rtl/uart_bus_port.sv
module uart_bus_port
  import uart_regs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_txc_bit,
  input  logic [DATA_W-1:0] head_data,
  input  logic              f_rxc,
  input  logic              f_txc,
  input  logic              f_dre,
  input  logic              f_ovr,
  output logic              data_wr,
  output logic              data_pop,
  output logic              txc_wclr,
  output logic [DATA_W-1:0] bus_rdata
);
  logic              sel_data, sel_stat;
  logic [DATA_W-1:0] stat_byte, rdata_q;

  assign sel_data = (bus_addr == ADDR_W'(AD_DATA));
  assign sel_stat = (bus_addr == ADDR_W'(AD_STAT));
  assign data_wr  = bus_wr && sel_data;
  assign data_pop = bus_rd && sel_data;
  assign txc_wclr = bus_wr && sel_stat && wr_txc_bit;

  always_comb begin
    stat_byte         = '0;
    stat_byte[SB_RXC] = f_rxc;
    stat_byte[SB_TXC] = f_txc;
    stat_byte[SB_DRE] = f_dre;
    stat_byte[SB_OVR] = f_ovr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      if (sel_data)      rdata_q <= head_data;
      else if (sel_stat) rdata_q <= stat_byte;
      else               rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/uart_regs.sv
module uart_regs
  import uart_regs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int RX_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              txc_ack,
  input  logic              tx_enable,
  input  logic              rx_enable,
  input  logic [CSEL_W-1:0] char_size,
  output logic              ser_load,
  output logic [DATA_W-1:0] ser_data,
  input  logic              ser_done,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_char,
  output logic              irq_rxc,
  output logic              irq_txc,
  output logic              irq_dre
);
  logic              data_wr, data_pop, txc_wclr;
  logic              f_rxc, f_txc, f_dre, f_ovr;
  logic [DATA_W-1:0] head_data;

  uart_bus_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .wr_txc_bit(bus_wdata[SB_TXC]), .head_data(head_data),
    .f_rxc(f_rxc), .f_txc(f_txc), .f_dre(f_dre), .f_ovr(f_ovr),
    .data_wr(data_wr), .data_pop(data_pop), .txc_wclr(txc_wclr),
    .bus_rdata(bus_rdata)
  );

  uart_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .wr_stb(data_wr), .wdata(bus_wdata),
    .tx_enable(tx_enable), .char_sel(char_size), .ser_done(ser_done),
    .txc_clr(txc_wclr || txc_ack), .ser_load(ser_load), .ser_data(ser_data),
    .dre(f_dre), .txc(f_txc)
  );

  uart_rx_queue #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst(rst), .rx_enable(rx_enable), .push_stb(rx_valid),
    .push_data(rx_char), .char_sel(char_size), .pop_stb(data_pop),
    .head_data(head_data), .not_empty(f_rxc), .overrun(f_ovr)
  );

  assign irq_rxc = f_rxc;
  assign irq_txc = f_txc;
  assign irq_dre = f_dre;

  a_r1_reset_flags: assert property (@(posedge clk)
    $past(rst) |-> (irq_dre && !irq_txc && !irq_rxc && !ser_load));
endmodule

// File: tb/uart_regs_tb.sv
module uart_regs_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       txc_ack = 0, tx_enable = 0, rx_enable = 1;
  logic [1:0] char_size = 2'd3;
  logic       ser_load, ser_done;
  logic [7:0] ser_data;
  logic       rx_valid = 0;
  logic [7:0] rx_char = 0;
  logic       irq_rxc, irq_txc, irq_dre;
  logic       man_done = 0, auto_done = 0, auto_en = 0;
  int         n_chk = 0, n_bad = 0, cyc = 0, ser_cnt = 0;
  logic [7:0] tx_log[$];
  logic [7:0] v;

  assign ser_done = man_done | auto_done;
  always #10 clk = ~clk;

  uart_regs u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txc_ack(txc_ack),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .char_size(char_size),
    .ser_load(ser_load), .ser_data(ser_data), .ser_done(ser_done),
    .rx_valid(rx_valid), .rx_char(rx_char),
    .irq_rxc(irq_rxc), .irq_txc(irq_txc), .irq_dre(irq_dre)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  // behavioural reference model
  logic [7:0] mq[$];
  bit         m_full, m_act, m_txc, m_ovr, m_load;
  logic [7:0] m_hold, m_sdata, m_rdata;

  always @(posedge clk) begin
    logic [7:0] mk, st;
    bit ld, fe, pop;
    cyc++;
    if (rst) begin
      mq.delete();
      m_full = 0; m_act = 0; m_txc = 0; m_ovr = 0; m_load = 0;
      m_hold = 0; m_sdata = 0; m_rdata = 0;
    end else begin
      mk = 8'hFF >> (3 - char_size);
      st = {mq.size() != 0, m_txc, !m_full, 1'b0, m_ovr, 3'b000};
      if (bus_rd) begin
        if (bus_addr == 0) m_rdata = (mq.size() != 0) ? mq[0] : 8'h00;
        else if (bus_addr == 1) m_rdata = st;
        else m_rdata = 8'h00;
      end
      pop = bus_rd && bus_addr == 0 && mq.size() != 0;
      if (!rx_enable) begin
        mq.delete();
        m_ovr = 0;
      end else begin
        if (pop) begin
          void'(mq.pop_front());
          m_ovr = 0;
        end
        if (rx_valid) begin
          if (mq.size() < 2) mq.push_back(rx_char & mk);
          else m_ovr = 1;
        end
      end
      ld = tx_enable && m_full && !m_act;
      fe = ser_done && m_act;
      if (fe && !m_full) m_txc = 1;
      else if ((bus_wr && bus_addr == 1 && bus_wdata[6]) || txc_ack) m_txc = 0;
      m_load = ld;
      if (ld) m_sdata = m_hold & mk;
      if (bus_wr && bus_addr == 0 && !m_full) begin
        m_hold = bus_wdata;
        m_full = 1;
      end else if (ld) m_full = 0;
      if (ld) m_act = 1;
      else if (fe) m_act = 0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(irq_dre == !m_full, "R2 dre", irq_dre, !m_full);
      chk(irq_rxc == (mq.size() != 0), "R8 rxc", irq_rxc, mq.size() != 0);
      chk(irq_txc == m_txc, "R5 txc", irq_txc, m_txc);
      chk(ser_load == m_load, "R4 load", ser_load, m_load);
      if (m_load) chk(ser_data == m_sdata, "R11 ser_data", ser_data, m_sdata);
      chk(bus_rdata == m_rdata, "R7 rdata", bus_rdata, m_rdata);
      if (ser_load) tx_log.push_back(ser_data);
    end
  end

  // automatic shifter stand-in
  always @(negedge clk) begin
    auto_done = 0;
    if (auto_en) begin
      if (ser_cnt > 0) begin
        ser_cnt--;
        if (ser_cnt == 0) auto_done = 1;
      end
      if (ser_load) ser_cnt = 2 + ($urandom % 6);
      if (ser_cnt == 0 && ($urandom % 100) < 2) auto_done = 1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 60000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=%0d exp=%0d", cyc, 60000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic rx_push(input logic [7:0] b);
    rx_valid = 1; rx_char = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic pulse_done();
    man_done = 1;
    @(negedge clk);
    man_done = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(irq_dre == 1 && irq_txc == 0 && irq_rxc == 0 && ser_load == 0, "R1 reset flags",
        {irq_dre, irq_txc, irq_rxc, ser_load}, 4'b1000);
    bus_read(1, v);
    chk(v == 8'h20, "R12 status after reset", v, 8'h20);

    // transmit path, held byte protected
    bus_write(0, 8'hA5);
    chk(irq_dre == 0, "R2 dre after write", irq_dre, 0);
    bus_write(0, 8'h3C);
    tx_enable = 1;
    repeat (3) @(negedge clk);
    chk(tx_log.size() == 1 && tx_log[0] == 8'hA5, "R3 ignored write", tx_log[0], 8'hA5);
    chk(irq_dre == 1, "R4 buffer freed", irq_dre, 1);
    pulse_done();
    chk(irq_txc == 1, "R5 txc set", irq_txc, 1);
    bus_write(1, 8'h00);
    chk(irq_txc == 1, "R6 write zero keeps", irq_txc, 1);
    bus_write(1, 8'h40);
    chk(irq_txc == 0, "R6 write one clears", irq_txc, 0);

    // 5-bit character on transmit
    char_size = 2'd0;
    bus_write(0, 8'hFF);
    repeat (2) @(negedge clk);
    chk(tx_log[$] == 8'h1F, "R11 tx mask", tx_log[$], 8'h1F);
    pulse_done();
    txc_ack = 1;
    @(negedge clk);
    txc_ack = 0;
    chk(irq_txc == 0, "R6 ack clears", irq_txc, 0);

    // frame end and clear in the same cycle
    char_size = 2'd3;
    bus_write(0, 8'h77);
    repeat (2) @(negedge clk);
    man_done = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 8'h40;
    @(negedge clk);
    man_done = 0; bus_wr = 0;
    chk(irq_txc == 1, "R6 set wins", irq_txc, 1);
    bus_write(1, 8'h40);

    // frame end while holding buffer is full
    bus_write(0, 8'h12);
    @(negedge clk);
    bus_write(0, 8'h34);
    pulse_done();
    chk(irq_txc == 0, "R5 no txc while full", irq_txc, 0);
    repeat (2) @(negedge clk);
    pulse_done();
    chk(irq_txc == 1 && tx_log[$] == 8'h34, "R5 txc after last", irq_txc, 1);
    bus_write(1, 8'h40);

    // receive queue and overrun
    rx_push(8'h81);
    rx_push(8'h42);
    chk(irq_rxc == 1, "R8 rxc set", irq_rxc, 1);
    rx_push(8'h99);
    bus_read(1, v);
    chk(v == 8'hA8, "R9 overrun status", v, 8'hA8);
    bus_read(0, v);
    chk(v == 8'h81, "R7 oldest first", v, 8'h81);
    bus_read(1, v);
    chk(v == 8'hA0, "R9 overrun cleared", v, 8'hA0);
    bus_read(0, v);
    chk(v == 8'h42, "R7 second byte", v, 8'h42);
    bus_read(0, v);
    chk(v == 8'h00, "R7 empty read", v, 8'h00);
    chk(irq_rxc == 0, "R8 rxc clear", irq_rxc, 0);

    char_size = 2'd1;
    rx_push(8'hF3);
    bus_read(0, v);
    chk(v == 8'h33, "R11 rx mask", v, 8'h33);
    char_size = 2'd3;

    // flush on receiver disable
    rx_push(8'h11);
    rx_push(8'h22);
    rx_enable = 0;
    @(negedge clk);
    chk(irq_rxc == 0, "R10 flushed", irq_rxc, 0);
    rx_push(8'h55);
    rx_enable = 1;
    @(negedge clk);
    chk(irq_rxc == 0, "R10 disabled drop", irq_rxc, 0);
    bus_read(0, v);
    chk(v == 8'h00, "R10 empty after flush", v, 8'h00);

    // pop and push on a full queue in one cycle
    rx_push(8'h01);
    rx_push(8'h02);
    bus_rd = 1; bus_addr = 0; rx_valid = 1; rx_char = 8'h03;
    @(negedge clk);
    bus_rd = 0; rx_valid = 0;
    chk(bus_rdata == 8'h01, "R9 concurrent pop", bus_rdata, 8'h01);
    bus_read(1, v);
    chk(v[3] == 0, "R9 no overrun on pop+push", v[3], 0);
    bus_read(0, v);
    chk(v == 8'h02, "R9 second kept", v, 8'h02);
    bus_read(0, v);
    chk(v == 8'h03, "R9 arrival kept", v, 8'h03);

    // random traffic against the model
    auto_en = 1;
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      bus_wr = (r < 15);
      bus_rd = (r >= 15 && r < 40);
      bus_addr = 2'($urandom % 4);
      bus_wdata = 8'($urandom);
      rx_valid = (($urandom % 100) < 25);
      rx_char = 8'($urandom);
      txc_ack = (($urandom % 100) < 3);
      if (i % 250 == 0) begin
        tx_enable = (($urandom % 10) < 8);
        rx_enable = (($urandom % 10) < 9);
        char_size = 2'($urandom % 4);
      end
      @(negedge clk);
    end
    bus_wr = 0; bus_rd = 0; rx_valid = 0; txc_ack = 0; auto_en = 0;
    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule